// File: doc/BRIEF.md
# Two-Line Startup-Then-Loop Bit Pattern Generator

This block drives two single-bit output lines from fixed bit patterns. Each line has its own 32-bit pattern, and the block sends one bit of it per step. After reset, each line plays its startup pattern once. The block then moves, with no idle step, into a pair of looping patterns that repeat until the next reset.

A down-counting divider sets the step rate. One counter indexes the bit position for both lines. A one-bit phase flag chooses between the startup pattern and the looping pattern.

The four patterns, the pattern length, the step period and the reset synchronizer depth are all parameters. A designer sets them at integration time. Nothing can be loaded while the block is running.

Reset is asynchronous and active-low. Release passes through a small synchronizer before the stepping logic sees it.

Top module: `wave_preamble_seq`

## Requirements
- R1: While `rst_ni` is low, both output lines read 0. Asserting `rst_ni` clears them at once, without waiting for a clock edge. It also returns the block to the startup phase at bit position 0.
- R2: The outputs change only on step edges, and step edges come exactly `STEP_CLKS` (default 32) clock edges apart. Between steps both lines hold their value.
- R3: The first step comes on the (`SYNC_STAGES`+1)-th rising edge after `rst_ni` goes high, with `SYNC_STAGES` defaulting to 2. On that step, line 0 takes bit 0 of `PRE_L0` and line 1 takes bit 0 of `PRE_L1`.
- R4: Step n, counted from 0, sends bit n of each line's pattern. Bits go out from the least significant bit toward bit `PAT_W`-1. The default `PAT_W` is 32.
- R5: The startup patterns play exactly once per reset. After the first loop cycle has started, no startup bit appears again until the next reset.
- R6: Step `PAT_W` sends bit 0 of `LOOP_L0` on line 0 and bit 0 of `LOOP_L1` on line 1. It follows startup bit `PAT_W`-1 directly, with no repeated bit and no idle step.
- R7: During the loop phase, step `PAT_W`+m sends bit (m mod `PAT_W`) of `LOOP_L0` on line 0 and of `LOOP_L1` on line 1.
- R8: Once the loop phase has been entered, the block stays in it until reset.
- R9: The bit index wraps from `PAT_W`-1 back to 0 on a step. Every loop pass after the first starts again at bit 0.
- R10: The defaults are startup patterns 0xFFE79F1F (line 0) and 0xFFE7801F (line 1), and loop patterns 0x0FFFFFFF (line 0) and 0x0E0FFFFF (line 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lines_o | output | 2 | Registered output lines; bit 0 is line 0, bit 1 is line 1 |

## Verification
Reset takes effect at the outputs without any clock edge. After release, the first step, carrying startup bit 0, becomes visible just after the third rising edge. That delay is two synchronizer stages plus the output register.

From then on, each new bit appears just after the rising edge that falls every `STEP_CLKS` edges. Between those edges the outputs must not move.

The bench keeps a behavioural count of edges since release. From that count it works out the expected pair of bits, using the step number alone. It compares that pair with the outputs 1 ns after every rising edge, so each check sees the register value that edge produced.

A mid-run reset checks that the startup patterns and the seamless switch into the loop play again from the beginning.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;

  typedef enum logic {
    PH_START = 1'b0,
    PH_LOOP  = 1'b1
  } seq_phase_e;

  localparam int unsigned NUM_LINES = 2;

endpackage

// File: rtl/wave_rst_sync.sv
module wave_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/wave_step_div.sv
module wave_step_div #(
  parameter int unsigned STEP_CLKS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);

  localparam int unsigned CW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(STEP_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    step_o = (cnt_q == '0);
    cnt_d  = step_o ? RELOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R2: after a step the divider counts a full period before the next one
  a_r2_period_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (cnt_q == RELOAD));

  a_r2_no_early_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > 1) |=> !step_o);

endmodule

// File: rtl/wave_bit_index.sv
module wave_bit_index
  import wave_seq_pkg::*;
#(
  parameter int unsigned PAT_W = 32,
  localparam int unsigned IW = (PAT_W > 1) ? $clog2(PAT_W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [IW-1:0] idx_o,
  output seq_phase_e    phase_o
);

  localparam logic [IW-1:0] LAST = IW'(PAT_W - 1);

  logic [IW-1:0] idx_q, idx_d;
  seq_phase_e    phase_q, phase_d;
  logic          at_last;

  always_comb begin
    at_last = (idx_q == LAST);
    idx_d   = idx_q;
    phase_d = phase_q;
    if (step_i) begin
      idx_d = at_last ? '0 : idx_q + 1'b1;
      if (at_last) phase_d = PH_LOOP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= PH_START;
    end else begin
      idx_q   <= idx_d;
      phase_q <= phase_d;
    end
  end

  assign idx_o   = idx_q;
  assign phase_o = phase_q;

  // R9: index wraps to bit 0 after the last bit
  a_r9_index_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && idx_q == LAST) |=> (idx_q == '0));

  // R8: loop phase is sticky until reset
  a_r8_phase_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LOOP) |=> (phase_q == PH_LOOP));

  // R6: the last startup bit hands over straight to the loop phase
  a_r6_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && idx_q == LAST && phase_q == PH_START) |=> (phase_q == PH_LOOP));

  // R4: index is frozen between steps
  a_r4_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(idx_q));

endmodule

// File: rtl/wave_line_out.sv
module wave_line_out
  import wave_seq_pkg::*;
#(
  parameter int unsigned PAT_W = 32,
  parameter logic [PAT_W-1:0] START_PAT = '0,
  parameter logic [PAT_W-1:0] LOOP_PAT  = '0,
  localparam int unsigned IW = (PAT_W > 1) ? $clog2(PAT_W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [IW-1:0] idx_i,
  input  seq_phase_e    phase_i,
  output logic          bit_o
);

  logic bit_q, bit_d, sel_bit;

  always_comb begin
    sel_bit = (phase_i == PH_START) ? START_PAT[idx_i] : LOOP_PAT[idx_i];
    bit_d   = step_i ? sel_bit : bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= 1'b0;
    else         bit_q <= bit_d;
  end

  assign bit_o = bit_q;

  // R2: line holds between steps
  a_r2_line_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(bit_q));

endmodule

// File: rtl/wave_preamble_seq.sv
module wave_preamble_seq
  import wave_seq_pkg::*;
#(
  parameter int unsigned PAT_W       = 32,
  parameter int unsigned STEP_CLKS   = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [PAT_W-1:0] PRE_L0  = 32'hFFE7_9F1F,
  parameter logic [PAT_W-1:0] PRE_L1  = 32'hFFE7_801F,
  parameter logic [PAT_W-1:0] LOOP_L0 = 32'h0FFF_FFFF,
  parameter logic [PAT_W-1:0] LOOP_L1 = 32'h0E0F_FFFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [1:0] lines_o
);

  localparam int unsigned IW = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam logic [NUM_LINES-1:0][PAT_W-1:0] START_TBL = {PRE_L1, PRE_L0};
  localparam logic [NUM_LINES-1:0][PAT_W-1:0] LOOP_TBL  = {LOOP_L1, LOOP_L0};

  logic          rst_int_n;
  logic          step;
  logic [IW-1:0] idx;
  seq_phase_e    phase;

  wave_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  wave_step_div #(.STEP_CLKS(STEP_CLKS)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .step_o (step)
  );

  wave_bit_index #(.PAT_W(PAT_W)) u_index (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .step_i  (step),
    .idx_o   (idx),
    .phase_o (phase)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    wave_line_out #(
      .PAT_W     (PAT_W),
      .START_PAT (START_TBL[g]),
      .LOOP_PAT  (LOOP_TBL[g])
    ) u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_int_n),
      .step_i  (step),
      .idx_i   (idx),
      .phase_i (phase),
      .bit_o   (lines_o[g])
    );
  end

  // R3: the first step after release is taken in the startup phase at bit 0
  a_r3_first_step: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    ($rose(rst_int_n) && step) |-> (phase == PH_START && idx == '0));

endmodule

// File: tb/wave_preamble_seq_bench.sv
module wave_preamble_seq_bench;

  localparam int unsigned PAT_W = 32;
  localparam int unsigned STEP  = 32;
  localparam int unsigned SYNC  = 2;
  localparam logic [31:0] P0 = 32'hFFE79F1F;
  localparam logic [31:0] P1 = 32'hFFE7801F;
  localparam logic [31:0] L0 = 32'h0FFFFFFF;
  localparam logic [31:0] L1 = 32'h0E0FFFFF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [1:0] lines;

  int unsigned vectors = 0;
  int unsigned errors  = 0;
  bit          done    = 1'b0;

  int          since_rel = 0;
  int          steps     = 0;
  logic [1:0]  exp_lines = 2'b00;
  string       tag       = "R1";

  always #2 clk = ~clk;

  wave_preamble_seq u_wave_preamble_seq (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .lines_o (lines)
  );

  // Behavioural reference model: counts edges since release, derives step number.
  always @(posedge clk) begin
    if (!rst_n) begin
      since_rel = 0;
      steps     = 0;
      exp_lines = 2'b00;
      tag       = "R1";
    end else begin
      since_rel++;
      if (since_rel >= SYNC + 1 && ((since_rel - SYNC - 1) % STEP) == 0) begin
        if (steps < PAT_W) begin
          exp_lines = {P1[steps], P0[steps]};
          tag = (steps == 0) ? "R3" : "R4";
        end else begin
          exp_lines = {L1[(steps - PAT_W) % PAT_W], L0[(steps - PAT_W) % PAT_W]};
          if (steps == PAT_W)                     tag = "R6";
          else if (steps < 2 * PAT_W)             tag = "R7";
          else if (((steps - PAT_W) % PAT_W) == 0) tag = "R9";
          else                                    tag = "R5";
        end
        if (tag == "R4" && steps == 1) tag = "R10";
        steps++;
      end else if (since_rel < SYNC + 1) begin
        tag = "R1";
      end else begin
        tag = "R2";
      end
    end
    #1;
    vectors++;
    if (lines !== exp_lines) begin
      errors++;
      $display("FAIL %s at step %0d edge %0d: actual %b expected %b",
               tag, steps, since_rel, lines, exp_lines);
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    #1;
    vectors++;
    if (lines !== 2'b00) begin
      errors++;
      $display("FAIL R1 async clear: actual %b expected 00", lines);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (STEP * PAT_W * 3 + 40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    vectors++;
    if (lines !== 2'b00) begin
      errors++;
      $display("FAIL R1 mid-run async clear: actual %b expected 00", lines);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (STEP * (PAT_W + 4)) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule